// File: doc/BRIEF.md
# Bitstream Header Ratio Selector

This block sits beside a 32-bit configuration image stream and watches its header as the words go by. A start-of-image pulse resets its word count. As the accepted words arrive, it takes an encryption indication from one word and a compression indication from a later word. It then chooses the 2-bit clock-to-data ratio code that the configuration port needs for that image. The data words are only observed. They continue to the configuration port unchanged, by a path outside this block.

The ratio code depends on the two captured flags and on the port width chosen for the image. That width is 16 bits for a partial image and 32 bits for a full image. The code is published together with a one-cycle valid strobe. If the image ends before the header has been seen in full, a one-cycle error strobe is raised in its place.

Top module: `hdr_ratio_sel`

## Requirements
- R1: While reset is active and in the first cycle after it, every output is 0.
- R2: The encrypted flag is 1 when bits [3:2] of the accepted word at index 69 (counted from 0 after the start pulse) are nonzero, and 0 otherwise. It takes this value in the cycle after that word is accepted.
- R3: The compressed flag is the inverse of bit 1 of the accepted word at index 229. It takes this value in the cycle after that word is accepted.
- R4: With a 16-bit width (widthSel = 0), the ratio code is 0 (x1) if the image is neither encrypted nor compressed, 2 (x4) if it is compressed, and 1 (x2) if it is encrypted but not compressed.
- R5: With a 32-bit width (widthSel = 1, sampled with word 229), the ratio code is the R4 code plus one.
- R6: ratioValid is high for exactly one cycle per image: the cycle after word 229 is accepted. Ratio code and flags are valid in that cycle.
- R7: An end-of-image pulse (eopIn) that arrives after a start pulse but before word 229 has been accepted gives exactly one shortErr cycle on the following cycle and no ratioValid. An end pulse that comes after word 229 gives no error.
- R8: The word index advances only in cycles where wordValid is high. Idle cycles between words, whatever their data, do not shift the capture positions.
- R9: A start pulse clears both flags and the ratio code in the next cycle and restarts the count. Words that arrive before any start pulse are ignored and raise no strobe.
- R10: Once the header has been captured, later words leave the flags and the ratio code unchanged, and raise no strobe, until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sopIn | input | 1 | Start-of-image pulse; a word in the same cycle has index 0 |
| eopIn | input | 1 | End-of-image pulse |
| wordValid | input | 1 | Word on wordData is accepted this cycle |
| wordData | input | 32 | Image word |
| widthSel | input | 1 | Port width for the image: 0 = 16 bits, 1 = 32 bits |
| encFlag | output | 1 | Image is encrypted |
| cmpFlag | output | 1 | Image is compressed |
| ratioCode | output | 2 | Clock-to-data ratio: 0 x1, 1 x2, 2 x4, 3 x8 |
| ratioValid | output | 1 | One-cycle strobe when the ratio is ready |
| shortErr | output | 1 | One-cycle strobe for an image that ends inside the header |

## Verification
The assertions assume that a start pulse never arrives in the same cycle as an end pulse. They also assume that the capture indices are nonzero and distinct, so that a start never coincides with a capture. The stimulus drives a start pulse alone, on a cycle of its own, and an end pulse alone, after the last word. Idle gaps of random length carry random data with wordValid low. This exercises the counting rule without breaking those assumptions.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

  typedef struct packed {
    logic clrAll;   // new image: wipe captured state
    logic capEnc;   // encryption word accepted now
    logic capCmp;   // compression word accepted now
    logic flagErr;  // image ended inside the header
  } hdrStrobe_t;

  localparam logic [1:0] RATIO_X1 = 2'd0;
  localparam logic [1:0] RATIO_X2 = 2'd1;
  localparam logic [1:0] RATIO_X4 = 2'd2;

endpackage

// File: rtl/hdr_ratio_ctrl.sv
module hdr_ratio_ctrl
  import hdr_ratio_pkg::*;
#(
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int CNT_W   = $clog2(CMP_IDX + 2)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sopIn,
  input  logic       eopIn,
  input  logic       wordValid,
  output hdrStrobe_t strobes
);

  localparam logic [CNT_W-1:0] ENC_POS  = CNT_W'(ENC_IDX);
  localparam logic [CNT_W-1:0] CMP_POS  = CNT_W'(CMP_IDX);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMP_IDX + 1);

  logic             active;
  logic [CNT_W-1:0] wordCnt;
  logic [CNT_W-1:0] curIdx;
  logic             live;
  logic             take;

  always_comb begin
    curIdx          = sopIn ? '0 : wordCnt;
    live            = sopIn | active;
    take            = wordValid & live;
    strobes.clrAll  = sopIn;
    strobes.capEnc  = take && (curIdx == ENC_POS);
    strobes.capCmp  = take && (curIdx == CMP_POS);
    strobes.flagErr = eopIn && live && !strobes.capCmp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      wordCnt <= '0;
    end else begin
      if (take)
        wordCnt <= curIdx + 1'b1;
      else if (sopIn)
        wordCnt <= '0;
      if (strobes.capCmp || strobes.flagErr)
        active <= 1'b0;
      else if (sopIn)
        active <= 1'b1;
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= CNT_LAST);

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wordValid && !sopIn) |=> $stable(wordCnt));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !sopIn) |-> (!strobes.capEnc && !strobes.capCmp && !strobes.flagErr));

endmodule

// File: rtl/hdr_ratio_dp.sv
module hdr_ratio_dp
  import hdr_ratio_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hdrStrobe_t        strobes,
  input  logic [DATA_W-1:0] wordData,
  input  logic              widthSel,
  output logic              encFlag,
  output logic              cmpFlag,
  output logic [1:0]        ratioCode,
  output logic              ratioValid,
  output logic              shortErr
);

  logic       encReg, cmpReg, validReg, errReg;
  logic [1:0] ratioReg;
  logic       encNext, cmpNext;
  logic [1:0] baseCode, ratioNext;
  logic       unusedData;

  assign unusedData = ^wordData;

  always_comb begin
    encNext = |wordData[ENC_LSB +: ENC_W];
    cmpNext = ~wordData[CMP_BIT];
    if (cmpNext)
      baseCode = RATIO_X4;
    else if (encReg)
      baseCode = RATIO_X2;
    else
      baseCode = RATIO_X1;
    ratioNext = baseCode + {1'b0, widthSel};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encReg   <= 1'b0;
      cmpReg   <= 1'b0;
      ratioReg <= '0;
      validReg <= 1'b0;
      errReg   <= 1'b0;
    end else begin
      if (strobes.clrAll) begin
        encReg   <= 1'b0;
        cmpReg   <= 1'b0;
        ratioReg <= '0;
      end
      if (strobes.capEnc)
        encReg <= encNext;
      if (strobes.capCmp) begin
        cmpReg   <= cmpNext;
        ratioReg <= ratioNext;
      end
      validReg <= strobes.capCmp;
      errReg   <= strobes.flagErr;
    end
  end

  assign encFlag    = encReg;
  assign cmpFlag    = cmpReg;
  assign ratioCode  = ratioReg;
  assign ratioValid = validReg;
  assign shortErr   = errReg;

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    validReg |=> !validReg);

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    errReg |=> !errReg);

  // R4
  cmp_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validReg && cmpReg) |-> ratioReg[1]);

  // R9
  sop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrAll |=> (!encReg && !cmpReg && ratioReg == 2'd0));

  // R6
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(validReg && errReg));

endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
  import hdr_ratio_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sopIn,
  input  logic              eopIn,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordData,
  input  logic              widthSel,
  output logic              encFlag,
  output logic              cmpFlag,
  output logic [1:0]        ratioCode,
  output logic              ratioValid,
  output logic              shortErr
);

  localparam int CNT_W = $clog2(CMP_IDX + 2);

  hdrStrobe_t strobes;

  hdr_ratio_ctrl #(
    .ENC_IDX(ENC_IDX),
    .CMP_IDX(CMP_IDX),
    .CNT_W  (CNT_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sopIn    (sopIn),
    .eopIn    (eopIn),
    .wordValid(wordValid),
    .strobes  (strobes)
  );

  hdr_ratio_dp #(
    .DATA_W (DATA_W),
    .ENC_LSB(ENC_LSB),
    .ENC_W  (ENC_W),
    .CMP_BIT(CMP_BIT)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wordData  (wordData),
    .widthSel  (widthSel),
    .encFlag   (encFlag),
    .cmpFlag   (cmpFlag),
    .ratioCode (ratioCode),
    .ratioValid(ratioValid),
    .shortErr  (shortErr)
  );

endmodule

// File: tb/test_hdr_ratio_sel.sv
module test_hdr_ratio_sel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sopIn = 1'b0;
  logic        eopIn = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        widthSel = 1'b0;
  logic        encFlag, cmpFlag, ratioValid, shortErr;
  logic [1:0]  ratioCode;

  int tests = 0;
  int fails = 0;
  int validSeen = 0;
  int errSeen = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hdr_ratio_sel i_hdr_ratio_sel (
    .clk(clk), .rstN(rstN), .sopIn(sopIn), .eopIn(eopIn),
    .wordValid(wordValid), .wordData(wordData), .widthSel(widthSel),
    .encFlag(encFlag), .cmpFlag(cmpFlag), .ratioCode(ratioCode),
    .ratioValid(ratioValid), .shortErr(shortErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (ratioValid) validSeen++;
      if (shortErr) errSeen++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRatio(bit enc, bit cmp, bit wide);
    int base;
    if (cmp) base = 2;
    else if (enc) base = 1;
    else base = 0;
    return base + (wide ? 1 : 0);
  endfunction

  task automatic runImage(int nWords, logic [1:0] encField, logic cmpBit,
                          logic wide, logic endMark, int gapPct);
    bit expEnc = (encField != 2'b00);
    bit expCmp = !cmpBit;
    int expR = expRatio(expEnc, expCmp, wide);
    validSeen = 0;
    errSeen = 0;
    @(negedge clk);
    sopIn = 1'b1; wordValid = 1'b0;
    @(negedge clk);
    sopIn = 1'b0;
    // R9: start pulse clears captured state
    chk(encFlag == 0 && cmpFlag == 0 && ratioCode == 0, "R9 clear",
        {encFlag, cmpFlag, ratioCode}, 0);
    for (int i = 0; i < nWords; i++) begin
      while ($urandom_range(99) < gapPct) begin
        wordValid = 1'b0; wordData = $urandom; widthSel = 1'($urandom_range(1));
        @(negedge clk);
      end
      wordData = $urandom;
      if (i == 69) wordData[3:2] = encField;
      if (i == 229) wordData[1] = cmpBit;
      widthSel = (i == 229) ? wide : 1'($urandom_range(1));
      wordValid = 1'b1;
      @(posedge clk); #1;
      if (i == 69) chk(encFlag == expEnc, "R2 enc", encFlag, expEnc);
      if (i == 229) begin
        chk(ratioValid == 1'b1, "R6 strobe", ratioValid, 1);
        chk(cmpFlag == expCmp, "R3 cmp", cmpFlag, expCmp);
        chk(encFlag == expEnc, "R2 enc hold", encFlag, expEnc);
        chk(ratioCode == 2'(expR), wide ? "R5 ratio" : "R4 ratio", ratioCode, expR);
      end
      @(negedge clk);
    end
    wordValid = 1'b0;
    if (endMark) begin
      eopIn = 1'b1;
      @(negedge clk);
      eopIn = 1'b0;
    end
    repeat (3) @(negedge clk);
    if (endMark)
      chk(errSeen == ((nWords < 230) ? 1 : 0), "R7 error", errSeen, (nWords < 230) ? 1 : 0);
    chk(validSeen == ((nWords >= 230) ? 1 : 0), "R6 count", validSeen, (nWords >= 230) ? 1 : 0);
    if (nWords > 230) begin
      // R10: trailing words leave the result untouched
      chk(ratioCode == 2'(expR) && cmpFlag == expCmp && encFlag == expEnc, "R10 hold",
          ratioCode, expR);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({encFlag, cmpFlag, ratioCode, ratioValid, shortErr} == 0, "R1 reset",
        {encFlag, cmpFlag, ratioCode, ratioValid, shortErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({encFlag, cmpFlag, ratioCode, ratioValid, shortErr} == 0, "R1 after release",
        {encFlag, cmpFlag, ratioCode, ratioValid, shortErr}, 0);

    // R9: words before any start pulse are ignored
    validSeen = 0; errSeen = 0;
    for (int i = 0; i < 250; i++) begin
      wordValid = 1'b1; wordData = 32'h0000_000C; widthSel = 1'b1;
      @(negedge clk);
    end
    wordValid = 1'b0;
    eopIn = 1'b1; @(negedge clk); eopIn = 1'b0;
    repeat (2) @(negedge clk);
    chk(validSeen == 0 && errSeen == 0 && encFlag == 0 && cmpFlag == 0, "R9 pre-start",
        validSeen + errSeen, 0);

    // R4 R5 R8: every flag and width combination, with idle gaps
    for (int e = 0; e < 4; e++)
      for (int c = 0; c < 2; c++)
        for (int w = 0; w < 2; w++)
          runImage(240, 2'(e), 1'(c), 1'(w), 1'b1, 15);

    // R7: short images and boundary lengths
    runImage(50, 2'b11, 1'b0, 1'b1, 1'b1, 0);
    runImage(100, 2'b01, 1'b0, 1'b0, 1'b1, 5);
    runImage(229, 2'b10, 1'b0, 1'b1, 1'b1, 0);
    runImage(230, 2'b00, 1'b0, 1'b1, 1'b1, 0);

    // R9: restart mid-image after a captured encrypted image
    runImage(235, 2'b11, 1'b1, 1'b0, 1'b0, 0);
    runImage(150, 2'b01, 1'b1, 1'b0, 1'b0, 10);
    runImage(232, 2'b00, 1'b1, 1'b0, 1'b1, 0);

    // random images
    for (int k = 0; k < 12; k++)
      runImage(int'($urandom_range(260, 200)), 2'($urandom_range(3)),
               1'($urandom_range(1)), 1'($urandom_range(1)), 1'b1,
               int'($urandom_range(30)));

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule